// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

A single-port synchronous SRAM with registered inputs and outputs. Reads and writes can follow each other on every clock with no idle cycle between them. A read returns its word two edges after its address. A write takes its data two edges after its address, so the data phase of a write lines up with the data phase of a read. Because of this alignment, a shared data bus never needs a turnaround gap. The read path is a plain output word plus a drive-valid flag, standing in for a tri-state bus.

An access is started by a load cycle. After that, advance cycles step an internal two-bit burst counter through up to four words. The counter follows either a linear or an interleaved order. A low clock enable qualifies every edge. When clock enable is high, the whole pipeline, the memory and the burst state hold. The output enable is a combinational mask on the drive flag.

Top module: `zt_sram`

## Requirements
- R1: An access starts on an edge only when `cke_n`=0, `load_n`=0, `cs0_n`=0, `cs1`=1 and `cs2_n`=0. It is a write when `wr_n`=0 and a read when `wr_n`=1. A load edge with any chip enable inactive is a deselect.
- R2: A read whose address is taken at enabled edge N shows the stored word on `rdata` after the next enabled edge, and `drive` is 1 from then on while `oe_n`=0.
- R3: A write whose address is taken at enabled edge N keeps `drive` at 0 after edge N+1, whatever the level of `oe_n`. Its data is taken from `wdata` at enabled edge N+2.
- R4: The word is four 9-bit lanes, with lane k at bits [9k+8:9k]. `lane_n[k]` is sampled with the address; lane k is written only when `lane_n[k]`=0, and all other lanes keep their previous contents.
- R5: While `cke_n`=1, an edge changes nothing: no memory write, no pipeline advance, no burst step, and `rdata` holds.
- R6: `oe_n` is not clocked. While `oe_n`=1, `drive` is 0; lowering `oe_n` raises `drive` at once when a read word is due.
- R7: After a deselect at edge N, `drive` is 0 after edge N+1.
- R8: An enabled edge with `load_n`=1 continues a running burst. It keeps the access type chosen at the load and ignores the chip enables and `wr_n`, but it samples `lane_n` for writes. With base address b and step i (1 to 3, counting modulo 4), the two low address bits become b+i modulo 4 when `order_ilv`=0 and b XOR i when `order_ilv`=1. The upper address bits stay fixed. With no burst running, the edge is idle.
- R9: After reset the device is deselected and `drive` is 0.
- R10: A read issued on the edge right after a write to the same address returns the newly written lanes merged with the old ones.
- R11: Reads and writes may alternate on consecutive enabled edges in any order, each returning or storing the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low |
| cs0_n | input | 1 | Chip enable 0, active low |
| cs1 | input | 1 | Chip enable 1, active high |
| cs2_n | input | 1 | Chip enable 2, active low |
| load_n | input | 1 | 0 loads a new address, 1 advances the burst |
| wr_n | input | 1 | Write select at load, active low |
| lane_n | input | 4 | Per-lane write selects, active low |
| addr | input | AW (8) | Word address |
| order_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata | input | 36 | Write data, taken two enabled edges after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 36 | Registered read word |
| drive | output | 1 | Read word is being driven |

## Verification
The hardest case to reach from the ports is a stall that falls between a write's address edge and its data edge, while the data bus carries a different value at the stalled edges. The stimulus reaches it in two ways. Directed sequences place stalls there on purpose and change `wdata` during them. Random runs also draw `cke_n` high often enough that stalls land inside bursts and inside write–read forwarding pairs. A bench-side reference memory, updated only on enabled edges, then shows any write taken during a stall or from the wrong edge.

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             cs0_n,
  input  logic             cs1,
  input  logic             cs2_n,
  input  logic             load_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_n,
  input  logic [AW-1:0]    addr,
  input  logic             order_ilv,
  input  logic [DW-1:0]    wdata,
  input  logic             oe_n,
  output logic [DW-1:0]    rdata,
  output logic             drive
);

  logic [DW-1:0] mem [DEPTH];

  logic          bact, bwr;
  logic [AW-1:0] bbase;
  logic [1:0]    bcnt;

  logic             s1_v, s1_w, s2_v, s2_w;
  logic [AW-1:0]    s1_a, s2_a;
  logic [LANES-1:0] s1_be, s2_be;
  logic [DW-1:0]    rq, fwd;

  wire go  = !cke_n;
  wire sel = !cs0_n && cs1 && !cs2_n;

  wire [1:0] nxt_cnt = bcnt + 2'd1;
  wire [1:0] adv_lo  = order_ilv ? (bbase[1:0] ^ nxt_cnt) : (bbase[1:0] + nxt_cnt);
  wire [AW-1:0] adv_a = {bbase[AW-1:2], adv_lo};

  wire          op_v = load_n ? bact : sel;
  wire          op_w = load_n ? bwr : !wr_n;
  wire [AW-1:0] op_a = load_n ? adv_a : addr;

  wire s2_hit = s2_v && s2_w && (s2_a == s1_a);

  always_comb begin
    fwd = mem[s1_a];
    for (int k = 0; k < LANES; k++)
      if (s2_hit && s2_be[k])
        fwd[k*LANE_W +: LANE_W] = wdata[k*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bact  <= 1'b0;
      bwr   <= 1'b0;
      bbase <= '0;
      bcnt  <= '0;
      s1_v  <= 1'b0;
      s1_w  <= 1'b0;
      s1_a  <= '0;
      s1_be <= '0;
      s2_v  <= 1'b0;
      s2_w  <= 1'b0;
      s2_a  <= '0;
      s2_be <= '0;
      rq    <= '0;
    end else if (go) begin
      if (!load_n) begin
        bact  <= sel;
        bwr   <= !wr_n;
        bbase <= addr;
        bcnt  <= '0;
      end else if (bact) begin
        bcnt <= nxt_cnt;
      end
      s1_v  <= op_v;
      s1_w  <= op_w;
      s1_a  <= op_a;
      s1_be <= ~lane_n;
      s2_v  <= s1_v;
      s2_w  <= s1_w;
      s2_a  <= s1_a;
      s2_be <= s1_be;
      if (s1_v && !s1_w) rq <= fwd;
    end
  end

  always_ff @(posedge clk) begin
    if (go && s2_v && s2_w)
      for (int k = 0; k < LANES; k++)
        if (s2_be[k])
          mem[s2_a][k*LANE_W +: LANE_W] <= wdata[k*LANE_W +: LANE_W];
  end

  assign rdata = rq;
  assign drive = s2_v && !s2_w && !oe_n;

endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke_n,
  input logic          cs0_n,
  input logic          cs1,
  input logic          cs2_n,
  input logic          load_n,
  input logic          wr_n,
  input logic          oe_n,
  input logic [DW-1:0] rdata,
  input logic          drive
);
  wire sel   = !cs0_n && cs1 && !cs2_n;
  wire rd_go = !cke_n && !load_n && sel && wr_n;
  wire wr_go = !cke_n && !load_n && sel && !wr_n;
  wire ds_go = !cke_n && !load_n && !sel;

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> !drive); // R9
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_go, 2) && $past(!cke_n) && !oe_n |-> drive); // R2
  AST_WRITE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_go, 2) && $past(!cke_n) |-> !drive); // R3
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ds_go, 2) && $past(!cke_n) |-> !drive); // R7
  AST_OE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drive); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(rdata)); // R5
endmodule

bind zt_sram zt_sram_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs0_n(cs0_n), .cs1(cs1),
  .cs2_n(cs2_n), .load_n(load_n), .wr_n(wr_n), .oe_n(oe_n),
  .rdata(rdata), .drive(drive)
);

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;
  localparam int DEPTH = 256;
  localparam int AW = 8;
  localparam int DW = 36;

  logic clk = 0, rst_n = 0;
  logic cke_n = 0, cs0_n = 1, cs1 = 0, cs2_n = 1, load_n = 0, wr_n = 1;
  logic [3:0] lane_n = 4'hf;
  logic [AW-1:0] addr = '0;
  logic order_ilv = 0, oe_n = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic drive;

  always #2.5 clk = ~clk;

  zt_sram u_zt_sram (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs0_n(cs0_n), .cs1(cs1),
    .cs2_n(cs2_n), .load_n(load_n), .wr_n(wr_n), .lane_n(lane_n),
    .addr(addr), .order_ilv(order_ilv), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .drive(drive)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [DW-1:0] m_mem [DEPTH];
  bit m_bact, m_bwr;
  logic [AW-1:0] m_base;
  int m_cnt;
  bit p1_v, p1_w, p2_v, p2_w;
  logic [AW-1:0] p1_a, p2_a;
  logic [3:0] p1_be, p2_be;
  logic [DW-1:0] e_rdata = '0;

  function automatic logic [AW-1:0] burst_addr(logic [AW-1:0] b, int i, bit ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ 2'(i)) : (b[1:0] + 2'(i));
    return {b[AW-1:2], lo};
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [3:0] be);
    logic [DW-1:0] r = old;
    for (int k = 0; k < 4; k++) if (be[k]) r[k*9 +: 9] = nw[k*9 +: 9];
    return r;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit sel, nv, nw;
    logic [AW-1:0] na;
    if (!rst_n) begin
      m_bact = 0; p1_v = 0; p2_v = 0; e_rdata = '0;
      return;
    end
    if (cke_n) return;
    if (p2_v && p2_w) m_mem[p2_a] = merge(m_mem[p2_a], wdata, p2_be);
    if (p1_v && !p1_w) e_rdata = m_mem[p1_a];
    p2_v = p1_v; p2_w = p1_w; p2_a = p1_a; p2_be = p1_be;
    sel = !cs0_n && cs1 && !cs2_n;
    if (!load_n) begin
      nv = sel; nw = !wr_n; na = addr;
      m_bact = sel; m_bwr = !wr_n; m_base = addr; m_cnt = 0;
    end else begin
      nv = m_bact; nw = m_bwr;
      if (m_bact) m_cnt = (m_cnt + 1) % 4;
      na = burst_addr(m_base, m_cnt, order_ilv);
    end
    p1_v = nv; p1_w = nw; p1_a = na; p1_be = ~lane_n;
  endtask

  task automatic tick(string tag);
    bit ed;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    ed = p2_v && !p2_w && !oe_n;
    chk(drive == ed, tag, "drive", DW'(drive), DW'(ed));
    if (ed) chk(rdata == e_rdata, tag, "rdata", rdata, e_rdata);
  endtask

  task automatic op(bit ld_n, bit w_n, logic [AW-1:0] a, logic [3:0] ln, string tag);
    cke_n = 0; cs0_n = 0; cs1 = 1; cs2_n = 0;
    load_n = ld_n; wr_n = w_n; addr = a; lane_n = ln;
    wdata = {$urandom(), $urandom()};
    tick(tag);
  endtask

  task automatic idle(string tag);
    cke_n = 0; cs0_n = 1; load_n = 0; wdata = {$urandom(), $urandom()};
    tick(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (3) tick("R9");
    rst_n = 1;
    tick("R9");
    chk(drive == 0, "R9", "drive after reset", DW'(drive), '0);

    for (int i = 0; i < DEPTH; i++) op(0, 0, AW'(i), 4'h0, "R11");
    idle("R11"); idle("R11");

    // R2 single read, R7 deselect after it
    op(0, 1, 8'd17, 4'h0, "R2");
    idle("R7"); idle("R7"); idle("R7");

    // R1: each inactive chip enable blocks a read
    for (int c = 0; c < 3; c++) begin
      cke_n = 0; load_n = 0; wr_n = 1; addr = 8'd3;
      cs0_n = (c == 0); cs1 = (c != 1); cs2_n = (c == 2);
      tick("R1");
      idle("R1"); idle("R1");
    end

    // R4 partial write then read
    op(0, 0, 8'd40, 4'b1010, "R4");
    idle("R4"); idle("R4");
    op(0, 1, 8'd40, 4'hf, "R4");
    idle("R4"); idle("R4");

    // R10 write then immediate read of same address
    op(0, 0, 8'd41, 4'b0110, "R10");
    op(0, 1, 8'd41, 4'hf, "R10");
    idle("R10"); idle("R10");

    // R3 write with oe_n low, R11 alternation
    oe_n = 0;
    op(0, 0, 8'd50, 4'h0, "R3");
    op(0, 1, 8'd51, 4'h0, "R11");
    op(0, 0, 8'd51, 4'h0, "R11");
    op(0, 1, 8'd50, 4'h0, "R11");
    idle("R3"); idle("R3");

    // R5 stall between write address and write data
    op(0, 0, 8'd60, 4'h0, "R5");
    for (int s = 0; s < 3; s++) begin
      cke_n = 1; load_n = 0; cs0_n = 0; wr_n = 0; addr = 8'd61;
      wdata = {$urandom(), $urandom()};
      tick("R5");
    end
    idle("R5"); idle("R5");
    op(0, 1, 8'd60, 4'hf, "R5");
    op(0, 1, 8'd61, 4'hf, "R5");
    cke_n = 1; tick("R5"); tick("R5");
    idle("R5"); idle("R5");

    // R6 asynchronous output enable
    op(0, 1, 8'd70, 4'hf, "R6");
    oe_n = 1;
    idle("R6");
    chk(drive == 0, "R6", "drive with oe_n high", DW'(drive), '0);
    oe_n = 0; #1;
    chk(drive == 1, "R6", "drive after oe_n low", DW'(drive), DW'(1));
    chk(rdata == e_rdata, "R6", "rdata", rdata, e_rdata);
    @(negedge clk);
    idle("R6");

    // R8 bursts, both orders, continuation ignores chip enables and wr_n
    for (int o = 0; o < 2; o++) begin
      order_ilv = o[0];
      op(0, 1, 8'd86, 4'hf, "R8");
      for (int i = 0; i < 3; i++) begin
        cs0_n = 1; wr_n = 0; load_n = 1; cke_n = 0;
        tick("R8");
      end
      idle("R8"); idle("R8");
      op(0, 0, 8'd93, 4'h0, "R8");
      for (int i = 0; i < 4; i++) begin
        cs1 = 0; wr_n = 1; load_n = 1; lane_n = 4'(i + 1);
        wdata = {$urandom(), $urandom()};
        tick("R8");
      end
      idle("R8"); idle("R8");
      for (int a = 92; a < 96; a++) op(0, 1, AW'(a), 4'hf, "R8");
      idle("R8"); idle("R8");
    end
    load_n = 1; cs0_n = 1; tick("R8"); tick("R8");

    // R11 random mixed traffic
    for (int n = 0; n < 4000; n++) begin
      cke_n = ($urandom_range(0, 9) == 0);
      oe_n = ($urandom_range(0, 9) == 0);
      load_n = ($urandom_range(0, 3) == 0);
      wr_n = $urandom_range(0, 1);
      cs0_n = ($urandom_range(0, 7) == 0);
      cs1 = ($urandom_range(0, 7) != 0);
      cs2_n = ($urandom_range(0, 7) == 0);
      lane_n = 4'($urandom());
      addr = AW'($urandom_range(0, 15));
      order_ilv = $urandom_range(0, 1);
      wdata = {$urandom(), $urandom()};
      tick("R11");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule